// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer that sits on a 32-bit memory-mapped register bus with word-aligned offsets. A prescaler divides the system clock into fixed timer ticks, nominally 10 ms each. A 15-bit down-counter counts those ticks from a programmable timeout. Software must keep reloading the counter. If the counter runs out, the block drives a system reset pulse, latches a sticky timed-out status and reloads itself from the last programmed timeout.

Every action that could defeat the watchdog is guarded by a 16-bit key that must be written as the full data word. The reload, the re-enable and the status clear each take one key. Turning the timer off takes two keys, written as two back-to-back bus writes. One tick before the reset, the block sets an early-warning event. That event drives an interrupt line through a mask bit, and software can also force it.

While the chip is in debug mode the timer is suspended, unless software has set an override bit.

Top module: `kwdt_top`

## Requirements
- R1: After reset the timer is disabled, so offset 0x0C reads 0x0000DABE. The status at 0x10 reads 0, the count equals the DEF_TIMEOUT parameter, and both irq_o and sys_reset_o are low.
- R2: Writing the word 0x0000FEED to offset 0x00 loads the counter from the timeout register and restarts the prescaler. Any other data word written there leaves the count unchanged.
- R3: The timeout register at offset 0x04 keeps only data bits 14:0, and reads them back with bits 31:15 zero.
- R4: While the timer runs, the count drops by one every PRE_DIV clock cycles after a reload. Offset 0x14 returns the count in bits 14:0. Bit 15 of that register is 1 only in the cycle that follows a change of the count.
- R5: Writing 0x00002BAD to 0x08 and then 0x0000CAFE to 0x0C, as the very next bus write, disables the timer. Any other write in between cancels the sequence. While disabled the count holds still, and 0x0C reads 0x0000DABE; while enabled it reads 0.
- R6: While disabled, writing 0x0000ACED to offset 0x1C enables the timer. Any other value written there has no effect.
- R7: On the tick that takes the count to zero, sys_reset_o goes high in the following cycle and stays high for RST_CYCLES cycles. In the same cycle the status reads 0x0000CFE8 and the count reloads from the timeout register.
- R8: Writing 0x0000E8B4 to offset 0x10 clears the status to 0. Any other value written there leaves the status unchanged.
- R9: The event bit (bit 0 of offset 0x20) sets on the tick that takes the count from 2 to 1. Writing a 1 to that bit clears it. If a set and a clear arrive in the same cycle, the set wins.
- R10: irq_o is high exactly when the event bit and the mask bit (bit 0 of offset 0x24) are both 1.
- R11: Writing a 1 to bit 0 of offset 0x28 sets the event bit. That register always reads 0.
- R12: While dbg_mode_i is high and the override bit (bit 0 of offset 0x18) is 0, the count and the prescaler hold still. Setting the override bit lets them run. Offset 0x18 reads dbg_mode_i in bit 1 and the override bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address; the low two bits must be zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| dbg_mode_i | input | 1 | High while the chip is in debug mode |
| irq_o | output | 1 | Early-warning interrupt after the mask |
| sys_reset_o | output | 1 | Active-high system reset pulse |

## Verification
A bus write takes effect at the clock edge that samples it. Register readback is combinational, so the bench reads at the falling edge that follows the write. The count, its change flag, the event bit and the status all come from registers updated at the tick edge. The bench therefore counts the rising edges since the reload edge and compares each value against closed-form formulas in that edge count, sampling at every falling edge across one full timeout period and a few cycles past it. The reset pulse is due one register stage after the expiry edge, so the bench expects it on edges T·PRE_DIV through T·PRE_DIV+RST_CYCLES−1. Frozen-count checks read the count once, wait several whole prescaler periods and read it again.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    // Width of the tick counter and of the timeout field.
    localparam int unsigned TMO_W = 15;

    // Register word indices; software relies on these offsets.
    localparam int unsigned W_FEED = 0;
    localparam int unsigned W_TMO  = 1;
    localparam int unsigned W_DIS1 = 2;
    localparam int unsigned W_DIS2 = 3;
    localparam int unsigned W_STAT = 4;
    localparam int unsigned W_CNT  = 5;
    localparam int unsigned W_DBG  = 6;
    localparam int unsigned W_RES  = 7;
    localparam int unsigned W_EVT  = 8;
    localparam int unsigned W_MSK  = 9;
    localparam int unsigned W_FRC  = 10;

    // Keys and read codes.
    localparam logic [15:0] K_FEED    = 16'hFEED;
    localparam logic [15:0] K_ARM     = 16'h2BAD;
    localparam logic [15:0] K_KILL    = 16'hCAFE;
    localparam logic [15:0] K_RESUME  = 16'hACED;
    localparam logic [15:0] K_CLEAR   = 16'hE8B4;
    localparam logic [15:0] C_OFF     = 16'hDABE;
    localparam logic [15:0] C_EXPIRED = 16'hCFE8;
endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
    parameter int unsigned PRE_DIV = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick_o = run_i && (pre_q == LAST);
        pre_d  = pre_q;
        if (clr_i)       pre_d = '0;
        else if (tick_o) pre_d = '0;
        else if (run_i)  pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core #(
    parameter int unsigned CNT_W       = 15,
    parameter int unsigned DEF_TIMEOUT = 6000,
    parameter int unsigned RST_CYCLES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             feed_i,
    input  logic             ack_i,
    input  logic             force_i,
    input  logic [CNT_W-1:0] timeout_i,
    output logic [CNT_W-1:0] count_o,
    output logic             upd_o,
    output logic             evt_o,
    output logic             expire_o,
    output logic             sys_reset_o
);
    localparam int unsigned RW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             upd;
        logic             evt;
        logic [RW-1:0]    rcnt;
    } core_t;

    core_t st_d, st_q;
    logic  warn;

    always_comb begin
        st_d     = st_q;
        expire_o = tick_i && !feed_i && (st_q.count <= CNT_W'(1));
        warn     = tick_i && !feed_i && (st_q.count == CNT_W'(2));

        if (feed_i)        st_d.count = timeout_i;
        else if (expire_o) st_d.count = timeout_i;
        else if (tick_i)   st_d.count = st_q.count - 1'b1;

        st_d.upd = (st_d.count != st_q.count);

        if (warn || force_i) st_d.evt = 1'b1;
        else if (ack_i)      st_d.evt = 1'b0;

        if (expire_o)                st_d.rcnt = RW'(RST_CYCLES);
        else if (st_q.rcnt != '0)    st_d.rcnt = st_q.rcnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count <= CNT_W'(DEF_TIMEOUT);
            st_q.upd   <= 1'b0;
            st_q.evt   <= 1'b0;
            st_q.rcnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o     = st_q.count;
    assign upd_o       = st_q.upd;
    assign evt_o       = st_q.evt;
    assign sys_reset_o = (st_q.rcnt != '0);
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DEF_TIMEOUT = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              expire_i,
    input  logic              dbg_mode_i,
    input  logic [TMO_W-1:0]  count_i,
    input  logic              upd_i,
    input  logic              evt_i,
    output logic [31:0]       bus_rdata,
    output logic [TMO_W-1:0]  timeout_o,
    output logic              enabled_o,
    output logic              timed_out_o,
    output logic              mask_o,
    output logic              dbg_en_o,
    output logic              feed_o,
    output logic              ack_o,
    output logic              force_o
);
    localparam int unsigned IW = ADDR_W - 2;

    typedef struct packed {
        logic [TMO_W-1:0] timeout;
        logic             enabled;
        logic             armed;
        logic             timed_out;
        logic             mask;
        logic             dbg_en;
    } regs_t;

    regs_t       st_d, st_q;
    logic        aligned, wr;
    logic [IW-1:0] idx;

    function automatic logic key_is(input logic [31:0] d, input logic [15:0] k);
        return d == {16'h0000, k};
    endfunction

    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        idx     = bus_addr[ADDR_W-1:2];
        wr      = bus_sel && bus_we && aligned;

        feed_o  = wr && (idx == IW'(W_FEED)) && key_is(bus_wdata, K_FEED);
        ack_o   = wr && (idx == IW'(W_EVT))  && bus_wdata[0];
        force_o = wr && (idx == IW'(W_FRC))  && bus_wdata[0];

        st_d = st_q;
        // Any write ends a pending disable sequence; the arming write restarts it.
        if (wr) st_d.armed = (idx == IW'(W_DIS1)) && key_is(bus_wdata, K_ARM);

        if (wr && (idx == IW'(W_TMO)))
            st_d.timeout = bus_wdata[TMO_W-1:0];

        if (wr && (idx == IW'(W_DIS2)) && key_is(bus_wdata, K_KILL) && st_q.armed)
            st_d.enabled = 1'b0;
        else if (wr && (idx == IW'(W_RES)) && key_is(bus_wdata, K_RESUME) && !st_q.enabled)
            st_d.enabled = 1'b1;

        if (expire_i)
            st_d.timed_out = 1'b1;
        else if (wr && (idx == IW'(W_STAT)) && key_is(bus_wdata, K_CLEAR))
            st_d.timed_out = 1'b0;

        if (wr && (idx == IW'(W_MSK))) st_d.mask   = bus_wdata[0];
        if (wr && (idx == IW'(W_DBG))) st_d.dbg_en = bus_wdata[0];
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (idx)
                IW'(W_TMO):  bus_rdata = {{(32-TMO_W){1'b0}}, st_q.timeout};
                IW'(W_DIS2): bus_rdata = {16'h0000, st_q.enabled ? 16'h0000 : C_OFF};
                IW'(W_STAT): bus_rdata = {16'h0000, st_q.timed_out ? C_EXPIRED : 16'h0000};
                IW'(W_CNT):  bus_rdata = {{(31-TMO_W){1'b0}}, upd_i, count_i};
                IW'(W_DBG):  bus_rdata = {30'd0, dbg_mode_i, st_q.dbg_en};
                IW'(W_EVT):  bus_rdata = {31'd0, evt_i};
                IW'(W_MSK):  bus_rdata = {31'd0, st_q.mask};
                default:     bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.timeout   <= TMO_W'(DEF_TIMEOUT);
            st_q.enabled   <= 1'b0;
            st_q.armed     <= 1'b0;
            st_q.timed_out <= 1'b0;
            st_q.mask      <= 1'b0;
            st_q.dbg_en    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign timeout_o   = st_q.timeout;
    assign enabled_o   = st_q.enabled;
    assign timed_out_o = st_q.timed_out;
    assign mask_o      = st_q.mask;
    assign dbg_en_o    = st_q.dbg_en;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned PRE_DIV     = 500000,
    parameter int unsigned DEF_TIMEOUT = 6000,
    parameter int unsigned RST_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dbg_mode_i,
    output logic              irq_o,
    output logic              sys_reset_o
);
    logic [TMO_W-1:0] timeout, count;
    logic enabled, timed_out, mask, dbg_en;
    logic feed_hit, ack_hit, force_hit;
    logic upd, evt, expire, tick, run;

    assign run   = enabled && (!dbg_mode_i || dbg_en);
    assign irq_o = evt && mask;

    kwdt_regs #(.ADDR_W(ADDR_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .expire_i(expire), .dbg_mode_i(dbg_mode_i),
        .count_i(count), .upd_i(upd), .evt_i(evt),
        .bus_rdata(bus_rdata), .timeout_o(timeout), .enabled_o(enabled),
        .timed_out_o(timed_out), .mask_o(mask), .dbg_en_o(dbg_en),
        .feed_o(feed_hit), .ack_o(ack_hit), .force_o(force_hit)
    );

    kwdt_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run), .clr_i(feed_hit), .tick_o(tick)
    );

    kwdt_core #(.CNT_W(TMO_W), .DEF_TIMEOUT(DEF_TIMEOUT), .RST_CYCLES(RST_CYCLES)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .feed_i(feed_hit),
        .ack_i(ack_hit), .force_i(force_hit), .timeout_i(timeout),
        .count_o(count), .upd_o(upd), .evt_o(evt), .expire_o(expire),
        .sys_reset_o(sys_reset_o)
    );
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              enabled,
    input logic              run,
    input logic              feed,
    input logic              force_ev,
    input logic              evt,
    input logic              timed_out,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  timeout,
    input logic              sys_reset_o
);
    // R5
    disable_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enabled) |-> $past(bus_sel && bus_we && bus_addr == ADDR_W'(8'h0C)
                                 && bus_wdata == 32'h0000CAFE));

    // R12
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !feed) |=> $stable(count));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !feed) |=> (count == $past(count) || count == CNT_W'($past(count) - 1'b1)
                            || count == $past(timeout)));

    // R7
    reset_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset_o) |-> timed_out);

    // R9
    warn_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt) |-> ($past(force_ev) || count == CNT_W'(1)));
endmodule

bind kwdt_top kwdt_chk #(.ADDR_W(ADDR_W), .CNT_W(kwdt_pkg::TMO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .enabled(enabled), .run(run),
    .feed(feed_hit), .force_ev(force_hit), .evt(evt), .timed_out(timed_out),
    .count(count), .timeout(timeout), .sys_reset_o(sys_reset_o)
);

// File: tb/test_kwdt_top.sv
module test_kwdt_top;
    localparam int unsigned DIV  = 4;
    localparam int unsigned RSTN = 3;
    localparam int unsigned DEFT = 50;
    localparam int unsigned T    = 10;

    localparam logic [7:0] A_FEED = 8'h00, A_TMO = 8'h04, A_DIS1 = 8'h08, A_DIS2 = 8'h0C,
                           A_STAT = 8'h10, A_CNT = 8'h14, A_DBG = 8'h18, A_RES = 8'h1C,
                           A_EVT = 8'h20, A_MSK = 8'h24, A_FRC = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_mode_i = 1'b0;
    logic        irq_o, sys_reset_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    kwdt_top #(.ADDR_W(8), .PRE_DIV(DIV), .DEF_TIMEOUT(DEFT), .RST_CYCLES(RSTN)) i_kwdt_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_mode_i(dbg_mode_i), .irq_o(irq_o), .sys_reset_o(sys_reset_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0;
        int exp_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_DIS2, v); chk("R1 disabled code", v, 32'h0000DABE);
        rd(A_STAT, v); chk("R1 status", v, 32'h0);
        rd(A_CNT, v);  chk("R1 count", v, DEFT);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 reset out", {31'd0, sys_reset_o}, 32'd0);

        // R3 timeout masking
        wr(A_TMO, 32'hFFFF_FFFF); rd(A_TMO, v); chk("R3 mask", v, 32'h7FFF);
        wr(A_TMO, T);            rd(A_TMO, v); chk("R3 value", v, T);

        // R2 feed key
        wr(A_FEED, 32'h0000_1234); rd(A_CNT, v); chk("R2 wrong key ignored", v, DEFT);
        wr(A_FEED, 32'h0001_FEED); rd(A_CNT, v); chk("R2 upper bits ignored", v, DEFT);
        wr(A_FEED, 32'h0000_FEED); rd(A_CNT, v); chk("R2 reload + R4 flag", v, 32'h8000 | T);
        @(negedge clk); rd(A_CNT, v); chk("R4 flag clears", v, T);

        // R6 resume key
        wr(A_RES, 32'h0000_ACEE); rd(A_DIS2, v); chk("R6 wrong key", v, 32'h0000DABE);
        wr(A_RES, 32'h0000_ACED); rd(A_DIS2, v); chk("R6 enabled", v, 32'h0);

        // R4, R7, R9 sweep over one period and past expiry
        wr(A_FEED, 32'h0000_FEED);
        for (int n = 1; n <= 44; n++) begin
            @(negedge clk);
            exp_cnt = (n < int'(T*DIV)) ? int'(T) - n / int'(DIV)
                                        : int'(T) - (n - int'(T*DIV)) / int'(DIV);
            rd(A_CNT, v);
            chk("R4 count", {17'd0, v[14:0]}, exp_cnt);
            chk("R4 update flag", {31'd0, v[15]}, {31'd0, n % int'(DIV) == 0});
            rd(A_EVT, v);
            chk("R9 warning event", v, {31'd0, n >= int'((T-1)*DIV)});
            chk("R7 reset pulse", {31'd0, sys_reset_o},
                {31'd0, n >= int'(T*DIV) && n < int'(T*DIV + RSTN)});
            rd(A_STAT, v);
            chk("R7 status", v, (n >= int'(T*DIV)) ? 32'h0000CFE8 : 32'h0);
        end

        // R9 acknowledge
        wr(A_EVT, 32'h1); rd(A_EVT, v); chk("R9 ack", v, 32'h0);
        // R8 status clear
        wr(A_STAT, 32'h0000_1234); rd(A_STAT, v); chk("R8 wrong key", v, 32'h0000CFE8);
        wr(A_STAT, 32'h0000_E8B4); rd(A_STAT, v); chk("R8 cleared", v, 32'h0);

        // R5 aborted and completed disable
        wr(A_DIS1, 32'h0000_2BAD); wr(A_MSK, 32'h0); wr(A_DIS2, 32'h0000_CAFE);
        rd(A_DIS2, v); chk("R5 aborted sequence", v, 32'h0);
        wr(A_DIS1, 32'h0000_2BAD); wr(A_DIS2, 32'h0000_CAFE);
        rd(A_DIS2, v); chk("R5 disabled", v, 32'h0000DABE);
        rd(A_CNT, c0);
        repeat (3*DIV) @(negedge clk);
        rd(A_CNT, v); chk("R5 count frozen", {17'd0, v[14:0]}, {17'd0, c0[14:0]});

        // R10, R11 mask and force
        wr(A_MSK, 32'h1); chk("R10 masked-in, no event", {31'd0, irq_o}, 32'd0);
        wr(A_FRC, 32'h1); chk("R11 force drives irq", {31'd0, irq_o}, 32'd1);
        rd(A_EVT, v); chk("R11 event set", v, 32'h1);
        rd(A_FRC, v); chk("R11 force reads zero", v, 32'h0);
        wr(A_EVT, 32'h1); chk("R10 irq after ack", {31'd0, irq_o}, 32'd0);
        wr(A_MSK, 32'h0); wr(A_FRC, 32'h1);
        chk("R10 masked out", {31'd0, irq_o}, 32'd0);
        rd(A_EVT, v); chk("R10 event still set", v, 32'h1);
        wr(A_EVT, 32'h1);

        // R12 debug suspension and override
        dbg_mode_i = 1'b1;
        wr(A_RES, 32'h0000_ACED);
        wr(A_FEED, 32'h0000_FEED);
        repeat (3*DIV) @(negedge clk);
        rd(A_CNT, v); chk("R12 suspended", {17'd0, v[14:0]}, T);
        rd(A_DBG, v); chk("R12 readback", v, 32'h2);
        wr(A_DBG, 32'h1); rd(A_DBG, v); chk("R12 override readback", v, 32'h3);
        wr(A_FEED, 32'h0000_FEED);
        repeat (2*DIV) @(negedge clk);
        rd(A_CNT, v); chk("R12 override counts", {17'd0, v[14:0]}, T - 2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule